// File: doc/BRIEF.md
# Dual-Mode Frequency Meter

This block measures the frequency of a digital input signal against the local reference clock. It has two modes. In direct mode the input edges go through a divide-by-five prescaler into a chain of decade counters. These counters are enabled for a fixed half-second gate. Because of this, the decimal result is one tenth of the input frequency in hertz and needs no further arithmetic.

In reciprocal mode the block runs a raw window of programmable length, given in tenths of a second. The window is then aligned to the input: it opens on the first input edge after the raw window starts, and it closes on the first input edge after the raw window ends. Since the input is sampled in the reference domain, the alignment is also on reference clock edges. While the aligned window is open, two binary counters run side by side. One counts input periods and the other counts reference clocks. Downstream logic forms the frequency as input count times reference frequency divided by reference count. The prescaler is bypassed in this mode, so no resolution is lost.

A measurement starts on a start pulse while the block is idle. Results appear together with a one-cycle done strobe and stay on the outputs until the next result.

Top module: `freq_meter`

## Requirements
- R1: After reset, done_o and ovf_o are low and bcd_o, in_cnt_o and ref_cnt_o are zero.
- R2: In direct mode the counting gate lasts exactly 5*TICKS_PER_TENTH reference cycles. done_o rises on the clock edge that comes 5*TICKS_PER_TENTH+1 edges after the edge that sampled start_i high.
- R3: In direct mode bcd_o equals floor(E/5), where E is the number of input rising edges that fall inside the gate. bcd_o is packed as 4-bit BCD digits, with the least significant digit in bits [3:0].
- R4: Every 4-bit digit of bcd_o holds a value from 0 to 9, and each digit carries into the next one when it passes 9.
- R5: In reciprocal mode with win_tenths_i = N, where 1..1000 is the valid range, the raw window is N*TICKS_PER_TENTH cycles long. in_cnt_o is the number of input periods from the opening edge to the closing edge. ref_cnt_o is the number of reference cycles over the same span. For a steady input of period P cycles, ref_cnt_o = in_cnt_o*P and W-P < ref_cnt_o < W+P.
- R6: done_o is high for exactly one cycle per measurement, and all result outputs stay unchanged between done pulses.
- R7: All counters clear when a measurement starts. After a direct measurement in_cnt_o and ref_cnt_o are zero, and after a reciprocal one bcd_o is zero.
- R8: ovf_o is latched with the results and is 1 if any counter wrapped during that measurement. A wrapped binary counter shows its value modulo 2^CNT_W. The flag clears at the next measurement.
- R9: mode_i (0 = direct, 1 = reciprocal) and win_tenths_i are sampled only when a measurement starts. Changes to them, and start pulses, have no effect while a measurement is running.
- R10: A window setting of 0 is treated as 1, and any setting above 1000 is treated as 1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_i | input | 1 | Signal under measurement, asynchronous |
| start_i | input | 1 | Start pulse, accepted only when idle |
| mode_i | input | 1 | 0 = direct gated count, 1 = reciprocal |
| win_tenths_i | input | SEL_W | Reciprocal window length in tenths of a second |
| done_o | output | 1 | One-cycle result strobe |
| ovf_o | output | 1 | Counter wrapped during the measurement |
| bcd_o | output | NDIG*4 | Direct-mode decimal result |
| in_cnt_o | output | CNT_W | Reciprocal input period count |
| ref_cnt_o | output | CNT_W | Reciprocal reference cycle count |

## Verification
The hardest case to reach is the wrap of a reciprocal counter. Its width is normally far larger than any window a bench can afford. The bench therefore shrinks the reference counter to eight bits and the tenth-second tick to 60 cycles, then picks a window that pushes the reference count past 255. It also checks that the wrapped value is the true product modulo 256. Phase uncertainty at the window edges is handled by checking the exact period relation together with a bound of one period, not a single fixed count. The direct-mode periods are chosen to divide the gate, which makes the expected edge count exact at any phase.

// File: rtl/freqm_pkg.sv
package freqm_pkg;

    typedef enum logic {
        MODE_DIRECT = 1'b0,
        MODE_RECIP  = 1'b1
    } meas_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GATE,
        ST_ARM,
        ST_OPEN,
        ST_FIN
    } meas_state_e;

    typedef struct packed {
        logic cnt_clr;
        logic gate_on;
        logic win_open;
        logic fin;
    } meas_ctl_s;

    localparam int unsigned MIN_TENTHS  = 1;
    localparam int unsigned MAX_TENTHS  = 1000;
    localparam int unsigned GATE_TENTHS = 5;
    localparam int unsigned PRESCALE    = 5;

    function automatic int unsigned clamp_tenths(input int unsigned v);
        if (v < MIN_TENTHS) return MIN_TENTHS;
        if (v > MAX_TENTHS) return MAX_TENTHS;
        return v;
    endfunction

endpackage

// File: rtl/freqm_insync.sv
module freqm_insync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_i,
    output logic rise_o
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-1:0], sig_i};
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/freqm_bcd_chain.sv
module freqm_bcd_chain #(
    parameter int NDIG = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr_i,
    input  logic            inc_i,
    output logic [NDIG*4-1:0] digits_o,
    output logic            wrap_o
);
    logic [NDIG:0] carry;
    assign carry[0] = inc_i;

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        logic [3:0] d_q;
        assign carry[g+1]       = carry[g] & (d_q == 4'd9);
        assign digits_o[g*4 +: 4] = d_q;
        always_ff @(posedge clk) begin
            if (rst || clr_i)  d_q <= 4'd0;
            else if (carry[g]) d_q <= (d_q == 4'd9) ? 4'd0 : d_q + 4'd1;
        end
    end

    assign wrap_o = carry[NDIG];
endmodule

// File: rtl/freqm_win_ctl.sv
module freqm_win_ctl
    import freqm_pkg::*;
#(
    parameter int TICKS = 5_000_000,
    parameter int SEL_W = 10,
    parameter int TW    = 33
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             mode_i,
    input  logic [SEL_W-1:0] tenths_i,
    input  logic             rise_i,
    output meas_ctl_s        ctl_o
);
    localparam longint unsigned GATE_L = 64'(GATE_TENTHS) * 64'(TICKS);
    localparam logic [TW-1:0]   GATE_LAST = TW'(GATE_L - 1);

    meas_state_e  state_q;
    logic [TW-1:0] timer_q;
    logic [TW-1:0] win_q;
    logic          raw_done;

    assign raw_done = (timer_q >= win_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            timer_q <= '0;
            win_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) begin
                    timer_q <= '0;
                    win_q   <= TW'(clamp_tenths(32'(tenths_i))) * TW'(TICKS);
                    state_q <= (meas_mode_e'(mode_i) == MODE_RECIP) ? ST_ARM : ST_GATE;
                end
                ST_GATE: begin
                    timer_q <= timer_q + 1'b1;
                    if (timer_q == GATE_LAST) state_q <= ST_FIN;
                end
                ST_ARM: begin
                    if (!raw_done) timer_q <= timer_q + 1'b1;
                    if (rise_i)    state_q <= ST_OPEN;
                end
                ST_OPEN: begin
                    if (!raw_done) timer_q <= timer_q + 1'b1;
                    if (rise_i && raw_done) state_q <= ST_FIN;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl_o.cnt_clr  = (state_q == ST_IDLE) && start_i;
        ctl_o.gate_on  = (state_q == ST_GATE);
        ctl_o.win_open = (state_q == ST_OPEN);
        ctl_o.fin      = (state_q == ST_FIN);
    end
endmodule

// File: rtl/freq_meter.sv
module freq_meter
    import freqm_pkg::*;
#(
    parameter int TICKS_PER_TENTH = 5_000_000,
    parameter int NDIG            = 8,
    parameter int CNT_W           = 32,
    parameter int SEL_W           = 10,
    parameter int SYNC_STAGES     = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sig_i,
    input  logic               start_i,
    input  logic               mode_i,
    input  logic [SEL_W-1:0]   win_tenths_i,
    output logic               done_o,
    output logic               ovf_o,
    output logic [NDIG*4-1:0]  bcd_o,
    output logic [CNT_W-1:0]   in_cnt_o,
    output logic [CNT_W-1:0]   ref_cnt_o
);
    localparam longint unsigned MAXW_L = 64'(MAX_TENTHS) * 64'(TICKS_PER_TENTH);
    localparam int TW = $clog2(MAXW_L + 1);
    localparam int PW = $clog2(PRESCALE);

    logic          rise;
    meas_ctl_s     ctl;
    logic [PW-1:0] pre_q;
    logic          pre_tick;
    logic [NDIG*4-1:0] bcd_q;
    logic          bcd_wrap;
    logic [CNT_W-1:0] in_q, ref_q;
    logic          in_inc, ref_inc, ovf_q;

    freqm_insync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .sig_i(sig_i), .rise_o(rise)
    );

    freqm_win_ctl #(.TICKS(TICKS_PER_TENTH), .SEL_W(SEL_W), .TW(TW)) ctl_i (
        .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
        .tenths_i(win_tenths_i), .rise_i(rise), .ctl_o(ctl)
    );

    assign pre_tick = ctl.gate_on && rise && (pre_q == PW'(PRESCALE - 1));

    always_ff @(posedge clk) begin
        if (rst || ctl.cnt_clr)     pre_q <= '0;
        else if (ctl.gate_on && rise) pre_q <= pre_tick ? '0 : pre_q + 1'b1;
    end

    freqm_bcd_chain #(.NDIG(NDIG)) bcd_i (
        .clk(clk), .rst(rst), .clr_i(ctl.cnt_clr), .inc_i(pre_tick),
        .digits_o(bcd_q), .wrap_o(bcd_wrap)
    );

    assign in_inc  = ctl.win_open && rise;
    assign ref_inc = ctl.win_open;

    always_ff @(posedge clk) begin
        if (rst || ctl.cnt_clr) begin
            in_q  <= '0;
            ref_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (in_inc)  in_q  <= in_q + 1'b1;
            if (ref_inc) ref_q <= ref_q + 1'b1;
            if (bcd_wrap || (in_inc && &in_q) || (ref_inc && &ref_q)) ovf_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o    <= 1'b0;
            ovf_o     <= 1'b0;
            bcd_o     <= '0;
            in_cnt_o  <= '0;
            ref_cnt_o <= '0;
        end else begin
            done_o <= ctl.fin;
            if (ctl.fin) begin
                ovf_o     <= ovf_q;
                bcd_o     <= bcd_q;
                in_cnt_o  <= in_q;
                ref_cnt_o <= ref_q;
            end
        end
    end
endmodule

// File: rtl/freqm_checker.sv
module freqm_checker #(
    parameter int NDIG  = 8,
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              done_o,
    input logic              ovf_o,
    input logic [NDIG*4-1:0] bcd_o,
    input logic [CNT_W-1:0]  in_cnt_o,
    input logic [CNT_W-1:0]  ref_cnt_o
);
    function automatic logic digits_ok(input logic [NDIG*4-1:0] v);
        for (int i = 0; i < NDIG; i++)
            if (v[i*4 +: 4] > 4'd9) return 1'b0;
        return 1'b1;
    endfunction

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(bcd_o) && $stable(in_cnt_o) && $stable(ref_cnt_o) && $stable(ovf_o)));

    p_bcd_digits_r4: assert property (@(posedge clk) disable iff (rst)
        digits_ok(bcd_o));

    p_mode_excl_r7: assert property (@(posedge clk) disable iff (rst)
        (done_o && bcd_o != '0) |-> (in_cnt_o == '0 && ref_cnt_o == '0));

    p_recip_ratio_r5: assert property (@(posedge clk) disable iff (rst)
        (done_o && !ovf_o && in_cnt_o != '0) |-> ({1'b0, ref_cnt_o} >= {in_cnt_o, 1'b0}));
endmodule

bind freq_meter freqm_checker #(.NDIG(NDIG), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst(rst), .done_o(done_o), .ovf_o(ovf_o), .bcd_o(bcd_o),
    .in_cnt_o(in_cnt_o), .ref_cnt_o(ref_cnt_o)
);

// File: tb/freq_meter_tb_top.sv
`timescale 1ns/1ps
module freq_meter_tb_top;
    localparam int T    = 60;
    localparam int NDIG = 4;
    localparam int CW   = 8;
    localparam int G    = 5 * T;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sig_i = 1'b0;
    logic start_i = 1'b0;
    logic mode_i = 1'b0;
    logic [9:0] win_tenths_i = '0;
    logic done_o, ovf_o;
    logic [NDIG*4-1:0] bcd_o;
    logic [CW-1:0] in_cnt_o, ref_cnt_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int per = 4;
    int ph = 0;

    freq_meter #(.TICKS_PER_TENTH(T), .NDIG(NDIG), .CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .sig_i(sig_i), .start_i(start_i), .mode_i(mode_i),
        .win_tenths_i(win_tenths_i), .done_o(done_o), .ovf_o(ovf_o), .bcd_o(bcd_o),
        .in_cnt_o(in_cnt_o), .ref_cnt_o(ref_cnt_o)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        sig_i = (ph < per / 2);
        if (ph >= per - 1) ph = 0;
        else ph = ph + 1;
    end

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected done earlier", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int to_bcd(input int v);
        int r = 0;
        int x = v;
        for (int i = 0; i < NDIG; i++) begin
            r = r | ((x % 10) << (4 * i));
            x = x / 10;
        end
        return r;
    endfunction

    task automatic settle(input int p);
        per = p;
        repeat (2 * p + 8) @(negedge clk);
    endtask

    task automatic measure(input bit m, input int tenths, output int lat);
        @(negedge clk);
        mode_i = m;
        win_tenths_i = 10'(tenths);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (!done_o) begin
            @(negedge clk);
            lat = lat + 1;
        end
    endtask

    initial begin
        int lat;
        int w, n, r, expv;
        int dper[12] = '{2, 3, 4, 5, 6, 10, 12, 15, 20, 30, 60, 100};
        int rper[6]  = '{2, 3, 4, 5, 7, 10};

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(done_o == 0 && ovf_o == 0, "R1 flags", int'({done_o, ovf_o}), 0);
        check(bcd_o == 0 && in_cnt_o == 0 && ref_cnt_o == 0, "R1 results",
              int'(bcd_o) + int'(in_cnt_o) + int'(ref_cnt_o), 0);

        // direct sweep: periods dividing the gate give exactly G/per edges
        foreach (dper[i]) begin
            settle(dper[i]);
            measure(1'b0, 0, lat);
            expv = to_bcd((G / dper[i]) / 5);
            check(lat == G + 1, "R2 gate length", lat, G + 1);
            check(int'(bcd_o) == expv, "R3 bcd value", int'(bcd_o), expv);
            check(in_cnt_o == 0 && ref_cnt_o == 0, "R7 direct raw zero",
                  int'(in_cnt_o) + int'(ref_cnt_o), 0);
            check(ovf_o == 0, "R8 direct no ovf", int'(ovf_o), 0);
            @(negedge clk);
            check(done_o == 0, "R6 done one cycle", int'(done_o), 0);
        end

        // reciprocal sweep, win 0 exercises the clamp
        for (int t = 0; t < 4; t++) begin
            foreach (rper[i]) begin
                settle(rper[i]);
                measure(1'b1, t, lat);
                w = ((t == 0) ? 1 : t) * T;
                n = int'(in_cnt_o);
                r = int'(ref_cnt_o);
                check(n > 0 && r == n * rper[i], "R5 ref equals in times period", r, n * rper[i]);
                check(r > w - rper[i] && r < w + rper[i],
                      (t == 0) ? "R10 clamped window span" : "R5 window span", r, w);
                check(bcd_o == 0, "R7 recip bcd zero", int'(bcd_o), 0);
                check(ovf_o == 0, "R8 recip no ovf", int'(ovf_o), 0);
            end
        end

        // overflow of the reference counter: W=300, P=4 -> 75 periods, 300 mod 256
        settle(4);
        measure(1'b1, 5, lat);
        check(ovf_o == 1, "R8 ovf set", int'(ovf_o), 1);
        check(int'(in_cnt_o) == 75, "R8 in count", int'(in_cnt_o), 75);
        check(int'(ref_cnt_o) == 300 % 256, "R8 wrapped ref", int'(ref_cnt_o), 300 % 256);
        measure(1'b1, 1, lat);
        check(ovf_o == 0, "R8 ovf cleared next run", int'(ovf_o), 0);

        // mode and start changes while running are ignored
        settle(6);
        @(negedge clk);
        mode_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 0;
        while (!done_o) begin
            @(negedge clk);
            lat = lat + 1;
            if (lat == 10) begin
                mode_i = 1'b1;
                win_tenths_i = 10'd2;
                start_i = 1'b1;
            end
            if (lat == 11) start_i = 1'b0;
        end
        check(lat == G + 1, "R9 gate unaffected", lat, G + 1);
        check(int'(bcd_o) == to_bcd(10), "R9 direct result kept", int'(bcd_o), to_bcd(10));
        check(in_cnt_o == 0 && ref_cnt_o == 0, "R9 no recip counting",
              int'(in_cnt_o) + int'(ref_cnt_o), 0);
        repeat (20) @(negedge clk);
        check(done_o == 0 && int'(bcd_o) == to_bcd(10), "R6 result held", int'(bcd_o), to_bcd(10));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule